// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that moves one byte per transfer. Software reaches it through two 32-bit registers on a simple write-enable bus with combinational read data. To send a byte, software first stores it in the data register. It then writes the control register with three things: the chip-select levels, a clock-divider value and a start bit.

While the byte shifts out on MOSI, the block shifts the reply in from MISO, most significant bit first, in SPI mode 0. Software polls the busy flag in the control register. When busy clears, software reads the received byte from the data register.

The block drives three chip-select lines, and each line simply follows its control bit. An internal loopback option feeds MOSI back into the receive path in place of MISO, so the block can test itself without a slave attached.

Top module: `sbyte_spi`

## Requirements
- R1: After reset, all three chip-select lines are high and SCK is low. The control register reads `0x15 | (RST_DIV << 27)` (default RST_DIV = 31), with busy and loopback at 0. The data register reads 0.
- R2: The control register sits at byte offset 0x0. Chip select n (n = 0, 1, 2) takes control bit 2n. Its output line shows the written level from the cycle after the write.
- R3: Writing control bit 1 as 1 while idle starts a transfer. Bit 1 of a control read is busy. It reads 1 from the cycle after the start write until the transfer ends.
- R4: SCK idles low. With divider D in control bits 31:27, each SCK half-period lasts D+1 clocks. The first rising edge comes D+1 clocks after the start write. Busy and SCK fall in the same cycle, 16·(D+1) clocks after the start write.
- R5: MOSI presents the transmit byte most significant bit first. It changes only while SCK is low, so it is stable at every rising edge.
- R6: MISO is sampled at each rising SCK edge, first bit into the most significant position. The data register (byte offset 0x4) reads the received byte in bits 7:0 once busy has cleared.
- R7: Control bit 3 enables loopback. The received byte then equals the transmitted byte whatever MISO does. Bit 3 reads back as written.
- R8: A control write while busy updates the chip-select and divider fields. Its start bit is ignored: the transfer in progress ends at its normal time, and no second transfer follows.
- R9: Writing the data register only sets the next transmit byte. The data register's read value changes only when a transfer completes.
- R10: The divider field reads back as written. Control bits other than 0, 1, 2, 3, 4 and 31:27 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip-select levels, one per control bit 2n |

## Verification
The bench counts clocks from the start write to the first SCK rise and to the fall of busy, for several divider values. An off-by-one in the divider compare would move both counts. So would a design that drops busy one half-period early or late.

A slave model shifts a byte that differs from the transmit byte, and it also records MOSI at each rising edge. This catches a bit order swapped on either path and a sample taken on the wrong edge. In loopback, the received byte must match the transmit byte even with that slave driving, which exposes a MISO path that was never disconnected.

A start written mid-transfer must neither stretch nor repeat the transfer, while its chip-select change still takes effect. The bench also checks that a data write leaves the read value unchanged, which would fail if the transmit and receive bytes shared one register.

// File: rtl/sbyte_spi_pkg.sv
package sbyte_spi_pkg;

   localparam int CTRL_OFS  = 0;
   localparam int DATA_OFS  = 4;
   localparam int BUSY_BIT  = 1;
   localparam int START_BIT = 1;
   localparam int LOOP_BIT  = 3;
   localparam int DIV_LSB   = 27;

   // Chip-select n lives on an even control bit.
   function automatic int cs_bit(input int n);
      return 2 * n;
   endfunction

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

endpackage

// File: rtl/sbyte_spi_clkdiv.sv
module sbyte_spi_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   // >= keeps the count bounded if the divider is lowered mid-phase
   assign tick = run && (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || !run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sbyte_spi_shifter.sv
module sbyte_spi_shifter
   import sbyte_spi_pkg::*;
#(
   parameter int FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] tx_byte,
   input  logic                  tick,
   input  logic                  rx_in,
   output logic                  busy,
   output logic                  sck,
   output logic                  mosi,
   output logic [FRAME_BITS-1:0] rx_byte
);

   localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

   phase_t                ph;
   logic [FRAME_BITS-1:0] tx_sh;
   logic [FRAME_BITS-1:0] rx_sh;
   logic [CW-1:0]         bcnt;

   assign busy = (ph != PH_IDLE);
   assign mosi = tx_sh[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         sck     <= 1'b0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         bcnt    <= '0;
         rx_byte <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               sck <= 1'b0;
               if (start) begin
                  ph    <= PH_LOW;
                  tx_sh <= tx_byte;
                  bcnt  <= '0;
               end
            end
            PH_LOW: begin
               if (tick) begin
                  sck   <= 1'b1;
                  rx_sh <= {rx_sh[FRAME_BITS-2:0], rx_in};
                  ph    <= PH_HIGH;
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  sck <= 1'b0;
                  if (bcnt == LAST_BIT) begin
                     ph      <= PH_IDLE;
                     rx_byte <= rx_sh;
                  end else begin
                     tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                     bcnt  <= bcnt + 1'b1;
                     ph    <= PH_LOW;
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sbyte_spi_regs.sv
module sbyte_spi_regs
   import sbyte_spi_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int NUM_CS     = 3,
   parameter int DIV_W      = 5,
   parameter int RST_DIV    = 31,
   parameter int FRAME_BITS = 8,
   parameter bit HAS_LOOP   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wen,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  busy,
   input  logic [FRAME_BITS-1:0] rx_byte,
   output logic [DATA_W-1:0]     rdata,
   output logic [NUM_CS-1:0]     cs_lvl,
   output logic                  loop_en,
   output logic [DIV_W-1:0]      div,
   output logic [FRAME_BITS-1:0] tx_byte,
   output logic                  start
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic ctrl_hit;
   logic data_hit;

   assign ctrl_hit = wen && (addr == CTRL_A);
   assign data_hit = wen && (addr == DATA_A);
   assign start    = ctrl_hit && wdata[START_BIT] && !busy;

   for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_lvl[n] <= 1'b1;
         end else if (ctrl_hit) begin
            cs_lvl[n] <= wdata[cs_bit(n)];
         end
      end
   end

   if (HAS_LOOP) begin : g_loop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            loop_en <= 1'b0;
         end else if (ctrl_hit) begin
            loop_en <= wdata[LOOP_BIT];
         end
      end
   end else begin : g_noloop
      assign loop_en = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div     <= DIV_W'(RST_DIV);
         tx_byte <= '0;
      end else begin
         if (ctrl_hit) begin
            div <= wdata[DIV_LSB +: DIV_W];
         end
         if (data_hit) begin
            tx_byte <= wdata[FRAME_BITS-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == CTRL_A) begin
         rdata[BUSY_BIT] = busy;
         rdata[LOOP_BIT] = loop_en;
         for (int n = 0; n < NUM_CS; n++) begin
            rdata[cs_bit(n)] = cs_lvl[n];
         end
         rdata[DIV_LSB +: DIV_W] = div;
      end else if (addr == DATA_A) begin
         rdata[FRAME_BITS-1:0] = rx_byte;
      end
   end

endmodule

// File: rtl/sbyte_spi.sv
module sbyte_spi
   import sbyte_spi_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int NUM_CS     = 3,
   parameter int DIV_W      = 5,
   parameter int RST_DIV    = 31,
   parameter int FRAME_BITS = 8,
   parameter bit HAS_LOOP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs
);

   if (DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
      $error("divider field does not fit the control word");
   end
   if (RST_DIV >= (1 << DIV_W) || RST_DIV < 0) begin : g_bad_rst
      $error("reset divider exceeds the divider field");
   end
   if (cs_bit(NUM_CS - 1) >= DIV_LSB) begin : g_bad_cs
      $error("chip-select bits collide with the divider field");
   end
   if (FRAME_BITS < 2 || FRAME_BITS > DATA_W) begin : g_bad_frame
      $error("frame width out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address too narrow for both register offsets");
   end

   logic                  busy;
   logic                  start;
   logic                  tick;
   logic                  loop_en;
   logic                  rx_in;
   logic [DIV_W-1:0]      div;
   logic [FRAME_BITS-1:0] tx_byte;
   logic [FRAME_BITS-1:0] rx_byte;

   assign rx_in = loop_en ? spi_mosi : spi_miso;

   sbyte_spi_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .NUM_CS    (NUM_CS),
      .DIV_W     (DIV_W),
      .RST_DIV   (RST_DIV),
      .FRAME_BITS(FRAME_BITS),
      .HAS_LOOP  (HAS_LOOP)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen    (bus_wen),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .busy   (busy),
      .rx_byte(rx_byte),
      .rdata  (bus_rdata),
      .cs_lvl (spi_cs),
      .loop_en(loop_en),
      .div    (div),
      .tx_byte(tx_byte),
      .start  (start)
   );

   sbyte_spi_clkdiv #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .clr  (start),
      .div  (div),
      .tick (tick)
   );

   sbyte_spi_shifter #(
      .FRAME_BITS(FRAME_BITS)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tx_byte(tx_byte),
      .tick   (tick),
      .rx_in  (rx_in),
      .busy   (busy),
      .sck    (spi_sck),
      .mosi   (spi_mosi),
      .rx_byte(rx_byte)
   );

endmodule

// File: rtl/sbyte_spi_chk.sv
module sbyte_spi_chk
   import sbyte_spi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int NUM_CS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wen,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              busy,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs
);

   logic ctrl_wr;
   assign ctrl_wr = bus_wen && (bus_addr == ADDR_W'(CTRL_OFS));

   for (genvar n = 0; n < NUM_CS; n++) begin : g_cs_chk
      // R2
      cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_wr |=> (spi_cs[n] == $past(bus_wdata[cs_bit(n)])));
   end

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[START_BIT] && !busy) |=> busy);

   // R4
   idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);

   // R4
   end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(spi_sck));

   // R5
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   // R5
   mosi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $stable(spi_mosi));

endmodule

bind sbyte_spi sbyte_spi_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .NUM_CS(NUM_CS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wen  (bus_wen),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .busy     (busy),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi),
   .spi_cs   (spi_cs)
);

// File: tb/sbyte_spi_tb.sv
module sbyte_spi_tb;

   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_CTRL = 4'h0;
   localparam logic [AW-1:0] A_DATA = 4'h4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wen = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          spi_sck;
   logic          spi_mosi;
   logic          spi_miso;
   logic [2:0]    spi_cs;

   int errors = 0;
   int checks = 0;

   logic [7:0] slv_byte = '0;
   int         slv_idx = 0;
   logic [7:0] mosi_cap = '0;

   always #4 clk = ~clk;

   sbyte_spi u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wen  (bus_wen),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso),
      .spi_cs   (spi_cs)
   );

   // mode-0 slave: presents its next bit after every falling edge
   assign spi_miso = (slv_idx < 8) ? slv_byte[7 - slv_idx] : 1'b0;
   always @(negedge spi_sck) slv_idx <= slv_idx + 1;
   always @(posedge spi_sck) mosi_cap <= {mosi_cap[6:0], spi_mosi};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wen   = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wen   = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] ctrl_word(input logic [2:0] cs, input int dv,
                                             input bit go, input bit lp);
      return {5'(dv), 22'd0, cs[2], lp, cs[1], go, cs[0]};
   endfunction

   task automatic t_reset();
      logic [31:0] r;
      bus_rd(A_CTRL, r);
      chk("R1 ctrl after reset", r, 32'hF800_0015);
      bus_rd(A_DATA, r);
      chk("R1 data after reset", r, 32'h0);
      chk("R1 cs after reset", {29'd0, spi_cs}, 32'h7);
      chk("R1 sck after reset", {31'd0, spi_sck}, 32'h0);
   endtask

   task automatic t_cs_fields();
      logic [31:0] r;
      bus_wr(A_CTRL, ctrl_word(3'b110, 5, 1'b0, 1'b0));
      chk("R2 cs pattern 110", {29'd0, spi_cs}, 32'h6);
      bus_wr(A_CTRL, ctrl_word(3'b011, 9, 1'b0, 1'b0));
      chk("R2 cs pattern 011", {29'd0, spi_cs}, 32'h3);
      bus_rd(A_CTRL, r);
      chk("R10 divider readback", r, 32'h4800_0005);
      bus_wr(A_CTRL, 32'hFFFF_FFFD);
      bus_rd(A_CTRL, r);
      chk("R10 R7 unused bits zero", r, 32'hF800_001D);
      chk("R2 cs all high", {29'd0, spi_cs}, 32'h7);
      bus_wr(A_CTRL, ctrl_word(3'b111, 0, 1'b0, 1'b0));
   endtask

   task automatic t_xfer(input logic [7:0] tx, input logic [7:0] sv, input int dv,
                         input bit lp);
      logic [31:0] r;
      int cnt;
      int rise;
      bit b;
      bus_wr(A_DATA, {24'd0, tx});
      slv_byte = sv;
      slv_idx  = 0;
      mosi_cap = '0;
      bus_wr(A_CTRL, ctrl_word(3'b110, dv, 1'b1, lp));
      bus_rd(A_CTRL, r);
      chk("R3 busy after start", {31'd0, r[1]}, 32'h1);
      cnt  = 0;
      rise = -1;
      b    = 1'b1;
      while (b && cnt < 4000) begin
         @(negedge clk);
         #1;
         cnt++;
         if (rise < 0 && spi_sck) rise = cnt;
         b = bus_rdata[1];
      end
      chk("R4 first rising edge", rise, dv + 1);
      chk("R4 busy duration", cnt, 16 * (dv + 1));
      chk("R4 sck low at end", {31'd0, spi_sck}, 32'h0);
      chk("R5 mosi bits", {24'd0, mosi_cap}, {24'd0, tx});
      bus_rd(A_DATA, r);
      if (lp) chk("R7 loopback rx", r, {24'd0, tx});
      else    chk("R6 miso rx", r, {24'd0, sv});
   endtask

   task automatic t_busy_write();
      logic [31:0] r;
      int cnt;
      bit b;
      bus_wr(A_DATA, 32'h0000_0096);
      slv_byte = 8'h3C;
      slv_idx  = 0;
      bus_wr(A_CTRL, ctrl_word(3'b110, 1, 1'b1, 1'b0));
      cnt = 0;
      repeat (5) begin
         @(negedge clk);
         cnt++;
      end
      bus_wen   = 1'b1;
      bus_addr  = A_CTRL;
      bus_wdata = ctrl_word(3'b101, 1, 1'b1, 1'b0);
      @(negedge clk);
      bus_wen = 1'b0;
      cnt++;
      #1;
      chk("R8 cs updated while busy", {29'd0, spi_cs}, 32'h5);
      b = bus_rdata[1];
      while (b && cnt < 4000) begin
         @(negedge clk);
         #1;
         cnt++;
         b = bus_rdata[1];
      end
      chk("R8 transfer not restarted", cnt, 32);
      b = 1'b0;
      repeat (40) begin
         @(negedge clk);
         #1;
         if (bus_rdata[1]) b = 1'b1;
      end
      chk("R8 no second transfer", {31'd0, b}, 32'h0);
      bus_rd(A_DATA, r);
      chk("R8 rx of original transfer", r, 32'h3C);
   endtask

   task automatic t_data_hold();
      logic [31:0] r;
      bus_wr(A_DATA, 32'h0000_00E7);
      bus_rd(A_DATA, r);
      chk("R9 data write keeps rx", r, 32'h3C);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cs_fields();
      t_xfer(8'hA5, 8'h5A, 0, 1'b0);
      t_xfer(8'h81, 8'hC3, 1, 1'b0);
      t_xfer(8'h0F, 8'hF0, 3, 1'b0);
      t_xfer(8'h6B, 8'h00, 2, 1'b1);
      t_xfer(8'hFF, 8'h12, 31, 1'b0);
      t_busy_write();
      t_data_hold();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule